// File: doc/BRIEF.md
# ULPI Link-Side Register Access Sequencer

This block sits on the link side of an 8-bit ULPI bus. It turns single register requests (read or write, 8-bit address, 8-bit write data) into the command, address and data bytes that the PHY expects. It also returns read data. It follows the bus ownership rules: the link drives the data lines only while it owns the bus. A turnaround cycle is left undriven each time the direction line changes, and every byte is held until the PHY accepts it with NXT.

Register addresses from 00h to 3Fh travel in the low six bits of the command byte. Higher addresses put the escape code 2Fh (101111b) in those bits and send the full address as a separate byte once the PHY accepts the command. If the PHY takes the bus before the last outgoing byte is accepted, the access is dropped and restarted from the command byte once the bus is free again. While the PHY owns the bus, any status byte it sends (NXT low, outside the read-data slot) is copied to a side output one cycle later.

Requests use a valid/ready handshake: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Results use a valid/ready handshake too: `rsp_valid` and `rsp_rdata` stay stable until `rsp_ready` is seen high, and no new request is accepted until then. The status side output has no back-pressure.

Top module: `ulpi_reg_seq`

## Requirements
- R1: After reset the block shows no response, no status byte and STP low, and with DIR low it offers `req_ready`.
- R2: The link enables its data driver only in cycles where DIR is low in both the current and the previous clock cycle. It never drives during the turnaround cycle after any DIR edge, nor while DIR is high.
- R3: When the link owns the bus and has no access in progress, it drives 00h (no-operation).
- R4: For an address of 3Fh or below, the command byte is {10b, addr[5:0]} for a write and {11b, addr[5:0]} for a read. It is held unchanged until a cycle with NXT high.
- R5: For an address above 3Fh, the command byte carries 101111b in its low six bits. After it is accepted, the full 8-bit address is driven and held until NXT is high.
- R6: For a write, the data byte follows the last accepted address or command byte and is held until NXT is high. In the next cycle STP is high for exactly one cycle with the data lines at 00h.
- R7: For a read, the link drives 00h after the address phase and waits for DIR to rise. It captures the data lines in the first cycle after that turnaround, and presents the result on `rsp_rdata` once DIR has fallen.
- R8: If DIR rises before the last outgoing byte of an access is accepted, the access restarts from its command byte on the first cycle the link owns the bus again.
- R9: In a cycle where DIR is high in both the current and the previous cycle, NXT is low and the read-data slot of R7 is not active, the data byte appears on `rxcmd_data` with `rxcmd_valid` high one cycle later. Back-to-back bytes produce back-to-back strobes.
- R10: `req_ready` is high only in the idle state while the link owns the bus. `rsp_valid` and `rsp_rdata` hold until `rsp_ready` is high, and only then does the block return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 60 MHz ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request taken on this edge when valid is high |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access finished |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8 | Read result (meaningful after reads) |
| rxcmd_valid | output | 1 | Status byte forwarded from the PHY |
| rxcmd_data | output | 8 | Forwarded status byte |
| ulpi_dir | input | 1 | Bus direction, high when the PHY drives |
| ulpi_nxt | input | 1 | PHY accepts the current byte |
| ulpi_stp | output | 1 | Stop strobe ending a register write |
| ulpi_data_in | input | 8 | Data lines as seen from the link |
| ulpi_data_out | output | 8 | Value driven by the link |
| ulpi_data_oe | output | 1 | Link data driver enable |

## Verification
Every cycle, the assertions check the ownership rule (no drive while DIR is high or one cycle after it changed), that STP lasts one cycle with 00h on the bus, and that an unaccepted byte stays stable. They also check that the response holds under back-pressure and that forwarded status bytes follow a cycle with DIR high. The byte values themselves need the bench scenarios: the command prefix and immediate or escaped address for every one of the 256 addresses in both directions, the read value captured right after turnaround, and the restart from the command byte after a takeover in either the command or the address phase. Forwarding of back-to-back status bytes, and their suppression during the read-data slot or with NXT high, are also shown only by the scenarios.

// File: rtl/ulpi_seq_pkg.sv
package ulpi_seq_pkg;

  localparam int BYTE_W = 8;                 // ULPI data bus width
  localparam int IMM_W  = 6;                 // immediate address field width
  localparam int PFX_W  = BYTE_W - IMM_W;    // command type prefix width
  localparam int ADDR_W = 8;                 // register address width

  localparam logic [PFX_W-1:0]  PFX_REG_WR = 2'b10;
  localparam logic [PFX_W-1:0]  PFX_REG_RD = 2'b11;
  localparam logic [IMM_W-1:0]  EXT_ESC    = 6'b101111;
  localparam logic [BYTE_W-1:0] BUS_NOOP   = '0;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CMD,
    SQ_ADDR,
    SQ_WDATA,
    SQ_STP,
    SQ_RWAIT,
    SQ_RDATA,
    SQ_REND,
    SQ_RESP
  } sq_state_e;

  function automatic logic [BYTE_W-1:0] build_cmd(input logic wr,
                                                  input logic [ADDR_W-1:0] addr);
    logic [PFX_W-1:0] pfx;
    logic [IMM_W-1:0] imm;
    pfx = wr ? PFX_REG_WR : PFX_REG_RD;
    imm = (|addr[ADDR_W-1:IMM_W]) ? EXT_ESC : addr[IMM_W-1:0];
    return {pfx, imm};
  endfunction

endpackage

// File: rtl/ulpi_dir_track.sv
module ulpi_dir_track (
  input  logic clk,
  input  logic dir,
  output logic dir_q,
  output logic owned
);
  // Follows DIR even in reset so the ownership rule holds from the first edge.
  always_ff @(posedge clk) begin
    dir_q <= dir;
  end

  assign owned = !dir && !dir_q;
endmodule

// File: rtl/ulpi_rxcmd_tap.sv
module ulpi_rxcmd_tap
  import ulpi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              dir_q,
  input  logic              nxt,
  input  logic              rd_slot,
  input  logic [BYTE_W-1:0] bus_in,
  output logic              tap_valid,
  output logic [BYTE_W-1:0] tap_data
);
  logic take;
  assign take = dir && dir_q && !nxt && !rd_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_valid <= 1'b0;
      tap_data  <= '0;
    end else begin
      tap_valid <= take;
      if (take) tap_data <= bus_in;
    end
  end
endmodule

// File: rtl/ulpi_seq_fsm.sv
module ulpi_seq_fsm
  import ulpi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              owned,
  input  logic              dir,
  input  logic              nxt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              stp,
  output logic              rd_slot
);
  sq_state_e         st, st_nx;
  logic              lat_wr;
  logic [ADDR_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_wdata;
  logic [BYTE_W-1:0] rd_q;
  logic [BYTE_W-1:0] drv;
  logic              use_ext;
  logic              cap;
  logic              accept;

  assign use_ext = |lat_addr[ADDR_W-1:IMM_W];
  assign accept  = owned && nxt;

  always_comb begin
    st_nx     = st;
    drv       = BUS_NOOP;
    stp       = 1'b0;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    cap       = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        req_ready = owned;
        if (req_valid && owned) st_nx = SQ_CMD;
      end
      SQ_CMD: begin
        drv = build_cmd(lat_wr, lat_addr);
        if (accept) begin
          if (use_ext)     st_nx = SQ_ADDR;
          else if (lat_wr) st_nx = SQ_WDATA;
          else             st_nx = SQ_RWAIT;
        end
      end
      SQ_ADDR: begin
        drv = lat_addr[BYTE_W-1:0];
        if (dir)         st_nx = SQ_CMD;
        else if (accept) st_nx = lat_wr ? SQ_WDATA : SQ_RWAIT;
      end
      SQ_WDATA: begin
        drv = lat_wdata;
        if (dir)         st_nx = SQ_CMD;
        else if (accept) st_nx = SQ_STP;
      end
      SQ_STP: begin
        stp   = 1'b1;
        st_nx = SQ_RESP;
      end
      SQ_RWAIT: begin
        if (dir) st_nx = SQ_RDATA;
      end
      SQ_RDATA: begin
        if (dir) begin
          cap   = 1'b1;
          st_nx = SQ_REND;
        end else begin
          st_nx = SQ_RWAIT;
        end
      end
      SQ_REND: begin
        if (!dir) st_nx = SQ_RESP;
      end
      SQ_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) st_nx = SQ_IDLE;
      end
      default: st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rd_q      <= '0;
    end else begin
      st <= st_nx;
      if (st == SQ_IDLE && req_valid && owned) begin
        lat_wr    <= req_write;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (cap) rd_q <= bus_in;
    end
  end

  assign bus_oe    = owned;
  assign bus_out   = owned ? drv : BUS_NOOP;
  assign rsp_rdata = rd_q;
  assign rd_slot   = (st == SQ_RDATA);
endmodule

// File: rtl/ulpi_reg_seq.sv
module ulpi_reg_seq
  import ulpi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              rxcmd_valid,
  output logic [BYTE_W-1:0] rxcmd_data,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  output logic              ulpi_stp,
  input  logic [BYTE_W-1:0] ulpi_data_in,
  output logic [BYTE_W-1:0] ulpi_data_out,
  output logic              ulpi_data_oe
);
  logic dir_q;
  logic owned;
  logic rd_slot;

  ulpi_dir_track u_track (
    .clk   (clk),
    .dir   (ulpi_dir),
    .dir_q (dir_q),
    .owned (owned)
  );

  ulpi_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .owned     (owned),
    .dir       (ulpi_dir),
    .nxt       (ulpi_nxt),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .bus_in    (ulpi_data_in),
    .bus_out   (ulpi_data_out),
    .bus_oe    (ulpi_data_oe),
    .stp       (ulpi_stp),
    .rd_slot   (rd_slot)
  );

  ulpi_rxcmd_tap u_tap (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir       (ulpi_dir),
    .dir_q     (dir_q),
    .nxt       (ulpi_nxt),
    .rd_slot   (rd_slot),
    .bus_in    (ulpi_data_in),
    .tap_valid (rxcmd_valid),
    .tap_data  (rxcmd_data)
  );
endmodule

// File: rtl/ulpi_reg_seq_chk.sv
module ulpi_reg_seq_chk
  import ulpi_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dir,
  input logic              nxt,
  input logic              stp,
  input logic [BYTE_W-1:0] data_out,
  input logic              oe,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BYTE_W-1:0] rsp_rdata,
  input logic              rxcmd_valid
);
  AST_NO_DRIVE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (dir || $past(dir)) |-> !oe); // R2

  AST_READY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dir && !$past(dir) && !rsp_valid)); // R10

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !nxt && !stp && data_out != '0) |=> (!oe || data_out == $past(data_out))); // R4

  AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stp |=> !stp); // R6

  AST_STP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    stp |-> (data_out == '0)); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

  AST_RX_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    rxcmd_valid |-> $past(dir)); // R9
endmodule

bind ulpi_reg_seq ulpi_reg_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir         (ulpi_dir),
  .nxt         (ulpi_nxt),
  .stp         (ulpi_stp),
  .data_out    (ulpi_data_out),
  .oe          (ulpi_data_oe),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rxcmd_valid (rxcmd_valid)
);

// File: tb/ulpi_reg_seq_tb.sv
module ulpi_reg_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_write;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_rdata;
  logic       rxcmd_valid;
  logic [7:0] rxcmd_data;
  logic       ulpi_dir, ulpi_nxt, ulpi_stp, ulpi_data_oe;
  logic [7:0] ulpi_data_in, ulpi_data_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ulpi_reg_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rxcmd_valid(rxcmd_valid), .rxcmd_data(rxcmd_data),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt), .ulpi_stp(ulpi_stp),
    .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_of(input logic wr, input logic [7:0] a);
    return {wr ? 2'b10 : 2'b11, (a > 8'h3F) ? 6'h2F : a[5:0]};
  endfunction

  task automatic issue(input logic wr, input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic accept_byte(input string tag, input logic [7:0] exp, input int dly);
    for (int i = 0; i < dly; i++) begin
      chk8(tag, ulpi_data_out, exp);
      chk1({tag, " oe"}, ulpi_data_oe, 1'b1);
      @(negedge clk);
    end
    chk8(tag, ulpi_data_out, exp);
    ulpi_nxt = 1'b1;
    @(negedge clk);
    ulpi_nxt = 1'b0;
  endtask

  task automatic finish_rsp(input int w);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      chk1("R10 rsp held", rsp_valid, 1'b1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk1("R10 rsp dropped", rsp_valid, 1'b0);
    chk1("R10 ready in idle", req_ready, 1'b1);
  endtask

  task automatic addr_phase(input logic wr, input logic [7:0] a, input int dly);
    if (a > 8'h3F) begin
      accept_byte("R5 cmd", cmd_of(wr, a), dly);
      accept_byte("R5 addr", a, dly);
    end else begin
      accept_byte("R4 cmd", cmd_of(wr, a), dly);
    end
  endtask

  task automatic write_tail(input logic [7:0] d, input int dly, input int w);
    accept_byte("R6 data", d, dly);
    chk1("R6 stp high", ulpi_stp, 1'b1);
    chk8("R6 stp noop", ulpi_data_out, 8'h00);
    @(negedge clk);
    chk1("R6 stp single", ulpi_stp, 1'b0);
    chk1("R6 rsp", rsp_valid, 1'b1);
    finish_rsp(w);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int dly, input int w);
    issue(1'b1, a, d);
    addr_phase(1'b1, a, dly);
    write_tail(d, dly, w);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] rd, input int dly, input int w);
    issue(1'b0, a, 8'h00);
    addr_phase(1'b0, a, dly);
    chk8("R7 wait noop", ulpi_data_out, 8'h00);
    ulpi_dir = 1'b1;
    #1 chk1("R2 turnaround up", ulpi_data_oe, 1'b0);
    @(negedge clk);
    ulpi_data_in = rd;
    chk1("R2 phy owns", ulpi_data_oe, 1'b0);
    @(negedge clk);
    ulpi_data_in = 8'hEE;
    ulpi_dir = 1'b0;
    #1 chk1("R2 turnaround down", ulpi_data_oe, 1'b0);
    chk1("R9 read slot not forwarded", rxcmd_valid, 1'b0);
    @(negedge clk);
    chk1("R7 rsp", rsp_valid, 1'b1);
    chk8("R7 rdata", rsp_rdata, rd);
    finish_rsp(w);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1'b0; ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk1("R1 rsp", rsp_valid, 1'b0);
    chk1("R1 rx", rxcmd_valid, 1'b0);
    chk1("R1 stp", ulpi_stp, 1'b0);
    chk1("R1 ready", req_ready, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk8("R3 idle noop", ulpi_data_out, 8'h00);
      chk1("R3 idle oe", ulpi_data_oe, 1'b1);
    end

    // Status bytes while idle, including back-to-back and one with NXT high
    ulpi_dir = 1'b1;
    #1 chk1("R10 ready off when phy owns", req_ready, 1'b0);
    @(negedge clk); ulpi_data_in = 8'h4A;
    @(negedge clk); ulpi_data_in = 8'h4B;
    chk1("R9 rx1", rxcmd_valid, 1'b1); chk8("R9 rx1 data", rxcmd_data, 8'h4A);
    @(negedge clk); ulpi_data_in = 8'h77; ulpi_nxt = 1'b1;
    chk1("R9 rx2", rxcmd_valid, 1'b1); chk8("R9 rx2 data", rxcmd_data, 8'h4B);
    @(negedge clk); ulpi_nxt = 1'b0; ulpi_dir = 1'b0;
    chk1("R9 nxt high not forwarded", rxcmd_valid, 1'b0);
    @(negedge clk);
    chk1("R9 none after dir low", rxcmd_valid, 1'b0);

    // Takeover during the command byte: restart from the command byte
    issue(1'b1, 8'h12, 8'h5C);
    chk8("R4 cmd before abort", ulpi_data_out, 8'h92);
    ulpi_dir = 1'b1;
    #1 chk1("R2 abort release", ulpi_data_oe, 1'b0);
    @(negedge clk); ulpi_data_in = 8'h21;
    @(negedge clk); ulpi_dir = 1'b0;
    chk1("R9 rx during abort", rxcmd_valid, 1'b1); chk8("R9 rx abort data", rxcmd_data, 8'h21);
    #1 chk1("R2 turnaround after abort", ulpi_data_oe, 1'b0);
    @(negedge clk);
    chk8("R8 retry cmd", ulpi_data_out, 8'h92);
    chk1("R8 retry oe", ulpi_data_oe, 1'b1);
    addr_phase(1'b1, 8'h12, 1);
    write_tail(8'h5C, 0, 0);

    // Takeover during the extended address byte
    issue(1'b1, 8'h9C, 8'h33);
    accept_byte("R5 cmd", 8'hAF, 0);
    chk8("R5 addr before abort", ulpi_data_out, 8'h9C);
    ulpi_dir = 1'b1;
    @(negedge clk); @(negedge clk); ulpi_dir = 1'b0;
    @(negedge clk);
    chk8("R8 retry ext cmd", ulpi_data_out, 8'hAF);
    addr_phase(1'b1, 8'h9C, 0);
    write_tail(8'h33, 1, 1);

    // Sweep over every address in both directions
    for (int a = 0; a < 256; a++) begin
      do_write(8'(a), 8'(a) ^ 8'hA5, a % 3, a % 2);
      do_read(8'(a), 8'((a * 7 + 3) & 255), (a + 1) % 3, a % 3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule